// File: doc/BRIEF.md
# Narrow-to-Wide Write Packer

This block sits in front of the write port of a 36-bit FIFO. A producer hands it data on a bus whose active width is a 36-bit long word, an 18-bit half or a 9-bit byte. The packer gathers the narrow beats into full 36-bit words. Each word reaches the FIFO as a single push, so storage is only ever written in whole long words.

While a long word is still incomplete, its earlier beats wait in holding registers. The beat that completes the word is merged with those held lanes. The merged word is then pushed on the same clock edge that accepts that final beat. A byte-order setting chooses where the first beat lands: big-endian puts it at the most significant end and little-endian at the least significant end. The width and byte-order settings are sampled while reset is asserted and are then held fixed. A FIFO-full input holds off the producer.

Top module: `bus_pack_writer`

## Requirements
- R1: `cfg_size` selects the packing width: 0 is the 36-bit long word, 1 is the 18-bit half and 2 is the 9-bit byte. The value 3 behaves as the long word. `cfg_size` and `cfg_big_end` are captured only on clock edges where `rst` is high.
- R2: In long-word mode, every accepted write raises `fifo_push` in that same cycle, with `fifo_data` equal to `wr_data`.
- R3: In half mode, the first accepted half is held and nothing is pushed. The second accepted half pushes the assembled long word in its own cycle.
- R4: In byte mode, the first three accepted bytes are held. The fourth accepted byte pushes the assembled long word in its own cycle.
- R5: With `cfg_big_end` = 1, the first beat lands in the most significant position. In byte mode beats 1 to 4 fill bits [35:27], [26:18], [17:9] and [8:0]. In half mode the two halves fill [35:18] and then [17:0].
- R6: With `cfg_big_end` = 0, the first beat lands in the least significant position. In byte mode beats 1 to 4 fill bits [8:0], [17:9], [26:18] and [35:27]. In half mode the two halves fill [17:0] and then [35:18].
- R7: In long-word mode, the byte-order setting has no effect on `fifo_data`.
- R8: In byte mode only `wr_data[8:0]` is used, and in half mode only `wr_data[17:0]`. Higher input bits have no effect on the pushed word.
- R9: `wr_ready` is high exactly when `rst` is low and `fifo_full` is low. A write is accepted only when both `wr_en` and `wr_ready` are high. A beat presented while `wr_ready` is low is neither stored nor counted.
- R10: Reset discards any partly assembled long word and restarts the beat count. Changes to `cfg_size` or `cfg_big_end` after reset has been released have no effect.
- R11: `fifo_push` is high only in a cycle that accepts a completing beat. It is never high while `fifo_full` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; settings are sampled while it is high |
| cfg_size | input | 2 | Packing width select: 0 long word, 1 half, 2 byte, 3 long word |
| cfg_big_end | input | 1 | 1 places the first beat at the most significant end |
| wr_en | input | 1 | Producer write strobe |
| wr_data | input | 36 | Producer data; only the low active width is used |
| wr_ready | output | 1 | Producer may write in this cycle |
| fifo_full | input | 1 | FIFO cannot take a push in this cycle |
| fifo_push | output | 1 | Push the assembled long word |
| fifo_data | output | 36 | Assembled long word |

## Verification
`wr_ready`, `fifo_push` and `fifo_data` respond to the current inputs with zero cycles of latency, so a completing beat and its push belong to the same cycle. Held beats and the beat count take effect at the rising edge that accepts a beat. The bench drives each beat on a falling edge and compares all three outputs one nanosecond later, within the same cycle. Only after that comparison does the rising edge advance the reference model, so every expected value reflects exactly the beats accepted before that cycle.

// File: rtl/bpw_pkg.sv
package bpw_pkg;

  typedef enum logic [1:0] {
    SZ_LONG = 2'd0,
    SZ_HALF = 2'd1,
    SZ_BYTE = 2'd2
  } bsize_e;

  function automatic bsize_e decode_size(input logic [1:0] code);
    case (code)
      2'd1:    return SZ_HALF;
      2'd2:    return SZ_BYTE;
      default: return SZ_LONG;
    endcase
  endfunction

endpackage

// File: rtl/bpw_cfg_latch.sv
module bpw_cfg_latch
  import bpw_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] size_in,
  input  logic       big_in,
  output bsize_e     mode,
  output logic       big
);

  // Settings are sampled only while reset is asserted.
  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= decode_size(size_in);
      big  <= big_in;
    end
  end

endmodule

// File: rtl/bpw_beat_ctr.sv
module bpw_beat_ctr #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic [CNT_W-1:0] last_idx,
  output logic [CNT_W-1:0] cnt,
  output logic             last
);

  assign last = (cnt == last_idx);

  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (adv) cnt <= last ? '0 : cnt + CNT_W'(1);
  end

endmodule

// File: rtl/bpw_lane_pack.sv
module bpw_lane_pack #(
  parameter int LANE_W = 9,
  parameter int LANES  = 4,
  localparam int DATA_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [LANES-1:0]  sel,
  input  logic [DATA_W-1:0] src,
  output logic [DATA_W-1:0] word
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] hold_q;

    always_ff @(posedge clk) begin
      if (rst)                  hold_q <= '0;
      else if (load && sel[i])  hold_q <= src[i*LANE_W +: LANE_W];
    end

    assign word[i*LANE_W +: LANE_W] = sel[i] ? src[i*LANE_W +: LANE_W] : hold_q;
  end

endmodule

// File: rtl/bus_pack_writer.sv
module bus_pack_writer
  import bpw_pkg::*;
#(
  parameter int LANE_W = 9,
  parameter int LANES  = 4,
  localparam int DATA_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cfg_size,
  input  logic              cfg_big_end,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  input  logic              fifo_full,
  output logic              fifo_push,
  output logic [DATA_W-1:0] fifo_data
);

  localparam int CNT_W = (LANES > 2) ? $clog2(LANES) : 1;
  localparam int HALF  = LANES / 2;

  bsize_e            mode;
  logic              big;
  logic              accept;
  logic              last;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  last_idx;
  logic [CNT_W-1:0]  byte_idx;
  logic              half_idx;
  logic [LANES-1:0]  sel;
  logic [DATA_W-1:0] src;

  bpw_cfg_latch u_cfg (
    .clk     (clk),
    .rst     (rst),
    .size_in (cfg_size),
    .big_in  (cfg_big_end),
    .mode    (mode),
    .big     (big)
  );

  assign wr_ready = !rst && !fifo_full;
  assign accept   = wr_en && wr_ready;

  always_comb begin
    case (mode)
      SZ_HALF: last_idx = CNT_W'(1);
      SZ_BYTE: last_idx = CNT_W'(LANES - 1);
      default: last_idx = '0;
    endcase
  end

  bpw_beat_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .adv      (accept),
    .last_idx (last_idx),
    .cnt      (cnt),
    .last     (last)
  );

  assign byte_idx = big ? (CNT_W'(LANES - 1) - cnt) : cnt;
  assign half_idx = big ? ~cnt[0] : cnt[0];

  for (genvar i = 0; i < LANES; i++) begin : g_route
    localparam logic UPPER = (i >= HALF);
    logic              sel_i;
    logic [LANE_W-1:0] src_i;

    always_comb begin
      case (mode)
        SZ_BYTE: begin
          sel_i = (byte_idx == CNT_W'(i));
          src_i = wr_data[LANE_W-1:0];
        end
        SZ_HALF: begin
          sel_i = (half_idx == UPPER);
          src_i = wr_data[(i % HALF)*LANE_W +: LANE_W];
        end
        default: begin
          sel_i = 1'b1;
          src_i = wr_data[i*LANE_W +: LANE_W];
        end
      endcase
    end

    assign sel[i]                    = sel_i;
    assign src[i*LANE_W +: LANE_W]   = src_i;
  end

  bpw_lane_pack #(.LANE_W(LANE_W), .LANES(LANES)) u_pack (
    .clk  (clk),
    .rst  (rst),
    .load (accept && !last),
    .sel  (sel),
    .src  (src),
    .word (fifo_data)
  );

  assign fifo_push = accept && last;

endmodule

// File: rtl/bpw_chk.sv
module bpw_chk #(
  parameter int LANES  = 4,
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        cfg_size,
  input logic              wr_en,
  input logic              wr_ready,
  input logic [DATA_W-1:0] wr_data,
  input logic              fifo_full,
  input logic              fifo_push,
  input logic [DATA_W-1:0] fifo_data
);

  logic [7:0] seen_q;
  logic [7:0] need_m1_q;
  logic       long_q;
  logic       acc;

  assign acc = wr_en && wr_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q    <= '0;
      need_m1_q <= (cfg_size == 2'd1) ? 8'd1 :
                   (cfg_size == 2'd2) ? 8'(LANES - 1) : 8'd0;
      long_q    <= !(cfg_size == 2'd1 || cfg_size == 2'd2);
    end else if (acc) begin
      seen_q <= fifo_push ? 8'd0 : seen_q + 8'd1;
    end
  end

  // R11
  push_needs_accept_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_push |-> (wr_en && wr_ready));

  // R9
  ready_off_full_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_full |-> (!wr_ready && !fifo_push));

  // R4
  beat_count_chk: assert property (@(posedge clk) disable iff (rst)
    acc |-> (fifo_push == (seen_q == need_m1_q)));

  // R2
  long_passthru_chk: assert property (@(posedge clk) disable iff (rst)
    (fifo_push && long_q) |-> (fifo_data == wr_data));

endmodule

bind bus_pack_writer bpw_chk #(.LANES(LANES), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_size  (cfg_size),
  .wr_en     (wr_en),
  .wr_ready  (wr_ready),
  .wr_data   (wr_data),
  .fifo_full (fifo_full),
  .fifo_push (fifo_push),
  .fifo_data (fifo_data)
);

// File: tb/bus_pack_writer_bench.sv
`timescale 1ns/1ps
module bus_pack_writer_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cfg_size = 2'd0;
  logic        cfg_big_end = 1'b0;
  logic        wr_en = 1'b0;
  logic [35:0] wr_data = '0;
  logic        fifo_full = 1'b0;
  logic        wr_ready;
  logic        fifo_push;
  logic [35:0] fifo_data;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  int          m_need = 1;
  bit          m_big  = 0;
  int          m_cnt  = 0;
  logic [35:0] m_acc  = '0;

  always #5 clk = ~clk;

  bus_pack_writer u_bus_pack_writer (
    .clk(clk), .rst(rst), .cfg_size(cfg_size), .cfg_big_end(cfg_big_end),
    .wr_en(wr_en), .wr_data(wr_data), .wr_ready(wr_ready),
    .fifo_full(fifo_full), .fifo_push(fifo_push), .fifo_data(fifo_data)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [35:0] act, input logic [35:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [35:0] place(input logic [35:0] a, input int c,
                                        input logic [35:0] d);
    logic [35:0] r = a;
    int lane;
    if (m_need == 4) begin
      lane = m_big ? 3 - c : c;
      r[lane*9 +: 9] = d[8:0];
    end else if (m_need == 2) begin
      lane = m_big ? 1 - c : c;
      r[lane*18 +: 18] = d[17:0];
    end else begin
      r = d;
    end
    return r;
  endfunction

  task automatic do_reset(input logic [1:0] sz, input bit be);
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0; cfg_size = sz; cfg_big_end = be;
    #1;
    chk(wr_ready == 1'b0, "R9", "ready in reset", 36'(wr_ready), 36'd0);
    chk(fifo_push == 1'b0, "R11", "push in reset", 36'(fifo_push), 36'd0);
    @(posedge clk);
    @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    cfg_size = ~sz;
    cfg_big_end = ~be;
    m_need = (sz == 2'd1) ? 2 : (sz == 2'd2) ? 4 : 1;
    m_big = be;
    m_cnt = 0;
    m_acc = '0;
  endtask

  task automatic step(input bit en, input logic [35:0] d, input bit full,
                      input string tag);
    logic [35:0] exp_d;
    bit exp_push;
    @(negedge clk);
    wr_en = en; wr_data = d; fifo_full = full;
    #1;
    exp_push = en && !full && (m_cnt == m_need - 1);
    exp_d = place(m_acc, m_cnt, d);
    chk(wr_ready == !full, tag, "wr_ready", 36'(wr_ready), 36'(!full));
    chk(fifo_push == exp_push, tag, "fifo_push", 36'(fifo_push), 36'(exp_push));
    if (exp_push)
      chk(fifo_data == exp_d, tag, "fifo_data", fifo_data, exp_d);
    @(posedge clk);
    if (en && !full) begin
      if (m_cnt == m_need - 1) begin
        m_cnt = 0;
      end else begin
        m_acc = exp_d;
        m_cnt++;
      end
    end
  endtask

  function automatic logic [35:0] rnd();
    return 36'({$urandom(), $urandom()});
  endfunction

  initial begin
    // R2: long-word pass-through, with full cycles (R9)
    do_reset(2'd0, 1'b0);
    step(1, 36'h1_2345_6789, 0, "R2");
    step(1, 36'hF_EDCB_A987, 0, "R2");
    step(1, 36'h5_5555_5555, 1, "R9");
    step(0, 36'h0, 0, "R11");
    step(1, rnd(), 0, "R2");

    // R1: code 3 behaves as long word; R7: byte order ignored there
    do_reset(2'd3, 1'b1);
    step(1, 36'hA_BCDE_F012, 0, "R1");
    step(1, 36'h0_0000_01FF, 0, "R7");
    do_reset(2'd0, 1'b1);
    step(1, 36'h0_0000_01FF, 0, "R7");

    // R3, R5, R8: half mode big-endian with junk high bits
    do_reset(2'd1, 1'b1);
    step(1, 36'hF_FFC1_2345, 0, "R3");
    step(1, 36'h3_0002_ABCD, 0, "R5");
    step(1, {18'h2AAAA, 18'h11111}, 0, "R8");
    step(1, 36'h0, 1, "R9");
    step(0, 36'h0, 0, "R9");
    step(1, {18'h15555, 18'h2F0F0}, 0, "R8");

    // R6: half mode little-endian
    do_reset(2'd1, 1'b0);
    step(1, 36'h0_0001_2345, 0, "R6");
    step(1, 36'hF_FFC2_ABCD, 0, "R6");

    // R4, R5: byte mode big-endian
    do_reset(2'd2, 1'b1);
    for (int k = 0; k < 8; k++) step(1, 36'(9'h101 + k*9'h23), 0, "R4");
    step(1, 36'h0_0000_0011, 0, "R5");
    step(1, 36'h0_0000_0022, 0, "R5");
    step(0, 36'h0, 0, "R5");
    step(1, 36'h0_0000_0033, 0, "R5");
    step(1, 36'h0_0000_0044, 0, "R5");

    // R6, R8: byte mode little-endian with junk high bits
    do_reset(2'd2, 1'b0);
    for (int k = 0; k < 8; k++) step(1, rnd(), 0, "R8");
    step(1, 36'h0_0000_0001, 0, "R6");
    step(1, 36'h0_0000_0002, 0, "R6");
    step(1, 36'h0_0000_0003, 0, "R6");
    step(1, 36'h0_0000_0004, 0, "R6");

    // R10: partial word dropped by reset; settings changed after release ignored
    step(1, 36'h0_0000_01AA, 0, "R10");
    step(1, 36'h0_0000_01BB, 0, "R10");
    do_reset(2'd2, 1'b0);
    for (int k = 0; k < 4; k++) step(1, 36'(9'h010 + k), 0, "R10");

    // R11: completing beat blocked by full, then retried
    for (int k = 0; k < 3; k++) step(1, rnd(), 0, "R11");
    step(1, 36'h0_0000_0199, 1, "R11");
    step(1, 36'h0_0000_0199, 1, "R11");
    step(1, 36'h0_0000_0199, 0, "R11");
    step(1, rnd(), 0, "R11");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule